// File: doc/BRIEF.md
# Event-to-Sync Time Difference Unit

This block measures how long after a reference (sync) edge an event edge occurs. Both inputs are timestamped against one free-running coarse counter. For every accepted event, the block emits the signed difference between the event timestamp and the latest sync timestamp. Each input has its own edge-polarity select. A per-input retrigger holdoff silently discards edges that follow the input's last accepted edge too closely.

Accepted timestamps are not subtracted at once. They are first queued in a small FIFO, one entry per clock holding a sync flag, an event flag and the counter value. A drain stage takes entries out of the FIFO, tracks the current sync reference and performs the subtraction. The subtraction uses a selectable counter width (18, 27 or 34 bits), and the difference is sign-extended into the result word. Results leave through a valid/ready port, and a sticky flag records any timestamp lost to a full FIFO.

Top module: `tdiff_unit`

## Requirements
- R1: After reset, `res_valid` and `ovf` are both 0.
- R2: A result equals the timestamp of the event minus the timestamp of the most recent sync before it, both taken from the same counter. A sync and an event accepted in the same cycle pair with each other and give 0. A single sync serves every later event until the next sync is accepted.
- R3: A polarity bit of 0 selects the rising edge and 1 selects the falling edge. `sync_pol` and `event_pol` are set independently, so all four combinations are available.
- R4: A pulse one clock wide is captured on whichever edge its polarity selects. A level that is held high produces a single rising edge.
- R5: An edge is accepted only if at least HOLDOFF clock cycles have passed since the last accepted edge on the same input. A rejected edge produces no result and does not restart the interval.
- R6: `cfg_width` selects the modulus: 00 gives 18 bits, 01 gives 27 bits, and 10 or 11 gives 34 bits. The difference is taken modulo 2^w and read as two's complement. A gap larger than half the span therefore comes out negative.
- R7: An event accepted before any sync has been accepted since reset produces no result.
- R8: Up to DEPTH accepted entries wait in the FIFO, and one further result can wait in the output register. An accepted edge that arrives while the FIFO is full is dropped, and `ovf` is set and stays set until reset.
- R9: While `res_valid` is high and `res_ready` is low, `res_data` stays stable. Every result is delivered exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; the counter advances once per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 2 | Counter modulus select (see R6) |
| sync_pol | input | 1 | Sync edge select: 0 rising, 1 falling |
| event_pol | input | 1 | Event edge select: 0 rising, 1 falling |
| sync_in | input | 1 | Sync input, sampled on clk |
| event_in | input | 1 | Event input, sampled on clk |
| res_ready | input | 1 | Consumer ready for a result |
| res_valid | output | 1 | A result is presented |
| res_data | output | RES_W | Signed time difference in counter ticks |
| ovf | output | 1 | Sticky flag: a timestamp was lost to a full FIFO |

## Verification
Two situations are hard to reach from the ports. The first is a negative result. The event always follows its sync in time, so a negative value appears only when the gap exceeds half the selected span. The stimulus sets the 18-bit mode and waits a little more than 2^17 cycles between a sync and an event. The second is overflow. With `res_ready` held low, a burst of event pulses spaced just beyond the holdoff fills the output register and then the FIFO, and further events are dropped. A cycle-level reference model in the bench, built from queues and tick counts, predicts the output and the flag on every clock.

// File: rtl/tdu_pkg.sv
package tdu_pkg;
   localparam int W_SHORT = 18;
   localparam int W_MID   = 27;
   localparam int W_LONG  = 34;

   typedef enum logic [1:0] {
      WSEL_SHORT = 2'b00,
      WSEL_MID   = 2'b01,
      WSEL_LONG  = 2'b10,
      WSEL_ALT   = 2'b11
   } wsel_e;

   function automatic int sel_width(input logic [1:0] sel);
      case (wsel_e'(sel))
         WSEL_SHORT: return W_SHORT;
         WSEL_MID:   return W_MID;
         default:    return W_LONG;
      endcase
   endfunction
endpackage

// File: rtl/tdu_edge_gate.sv
module tdu_edge_gate #(
   parameter int HOLDOFF = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pol,
   input  logic din,
   output logic acc
);
   logic prev_q;
   logic edge_hit;

   assign edge_hit = pol ? (prev_q & ~din) : (~prev_q & din);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= din;
   end

   generate
      if (HOLDOFF <= 1) begin : g_nohold
         assign acc = edge_hit;
      end else begin : g_hold
         localparam int HW = $clog2(HOLDOFF);
         logic [HW-1:0] hold_q;
         assign acc = edge_hit && (hold_q == '0);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             hold_q <= '0;
            else if (acc)           hold_q <= HW'(HOLDOFF - 1);
            else if (hold_q != '0)  hold_q <= hold_q - 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/tdu_fifo.sv
module tdu_fifo #(
   parameter int W     = 36,
   parameter int DEPTH = 4,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic          empty,
   output logic          full,
   output logic [LW-1:0] level
);
   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_q, rd_q;
   logic          do_push, do_pop;

   assign empty   = (level == '0);
   assign full    = (level == LW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_q];

   function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         level <= '0;
      end else begin
         if (do_push) wr_q <= step(wr_q);
         if (do_pop)  rd_q <= step(rd_q);
         level <= level + LW'(do_push) - LW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_q] <= din;
   end
endmodule

// File: rtl/tdu_alu.sv
module tdu_alu
   import tdu_pkg::*;
#(
   parameter int CNT_W = 34,
   parameter int RES_W = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cfg_width,
   input  logic             head_valid,
   input  logic             head_sync,
   input  logic             head_event,
   input  logic [CNT_W-1:0] head_ts,
   output logic             pop,
   input  logic             res_ready,
   output logic             res_valid,
   output logic [RES_W-1:0] res_data,
   output logic             have_sync
);
   logic [CNT_W-1:0] last_sync_q;
   logic [CNT_W-1:0] ref_ts;
   logic [CNT_W-1:0] raw_diff;
   logic             emit;

   function automatic logic [RES_W-1:0] sext(input logic [CNT_W-1:0] d, input int w);
      logic [RES_W-1:0] r;
      for (int i = 0; i < RES_W; i++)
         r[i] = (i < w) ? d[i] : d[w-1];
      return r;
   endfunction

   assign pop      = head_valid && (!res_valid || res_ready);
   assign ref_ts   = head_sync ? head_ts : last_sync_q;
   assign raw_diff = head_ts - ref_ts;
   assign emit     = pop && head_event && (head_sync || have_sync);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_sync_q <= '0;
         have_sync   <= 1'b0;
         res_valid   <= 1'b0;
         res_data    <= '0;
      end else begin
         if (pop && head_sync) begin
            last_sync_q <= head_ts;
            have_sync   <= 1'b1;
         end
         if (emit) begin
            res_valid <= 1'b1;
            res_data  <= sext(raw_diff, sel_width(cfg_width));
         end else if (res_ready) begin
            res_valid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/tdiff_unit.sv
module tdiff_unit
   import tdu_pkg::*;
#(
   parameter int CNT_W   = 34,
   parameter int RES_W   = 40,
   parameter int HOLDOFF = 6,
   parameter int DEPTH   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cfg_width,
   input  logic             sync_pol,
   input  logic             event_pol,
   input  logic             sync_in,
   input  logic             event_in,
   input  logic             res_ready,
   output logic             res_valid,
   output logic [RES_W-1:0] res_data,
   output logic             ovf
);
   localparam int EW = CNT_W + 2;
   localparam int LW = $clog2(DEPTH + 1);

   generate
      if (CNT_W < W_LONG) begin : g_chk_cnt
         $error("CNT_W must cover the widest mode");
      end
      if (RES_W < CNT_W) begin : g_chk_res
         $error("RES_W must not be narrower than CNT_W");
      end
      if (DEPTH < 2) begin : g_chk_depth
         $error("DEPTH must be at least 2");
      end
      if (HOLDOFF < 1) begin : g_chk_hold
         $error("HOLDOFF must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             acc_sync, acc_event;
   logic             push, pop, fifo_empty, fifo_full;
   logic [EW-1:0]    wr_ent, rd_ent;
   logic [LW-1:0]    fifo_level;
   logic             have_sync;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   tdu_edge_gate #(.HOLDOFF(HOLDOFF)) u_sync_gate (
      .clk(clk), .rst_n(rst_n), .pol(sync_pol), .din(sync_in), .acc(acc_sync)
   );

   tdu_edge_gate #(.HOLDOFF(HOLDOFF)) u_event_gate (
      .clk(clk), .rst_n(rst_n), .pol(event_pol), .din(event_in), .acc(acc_event)
   );

   assign push   = acc_sync || acc_event;
   assign wr_ent = {acc_sync, acc_event, cnt_q};

   tdu_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(push), .din(wr_ent),
      .pop(pop), .dout(rd_ent),
      .empty(fifo_empty), .full(fifo_full), .level(fifo_level)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                ovf <= 1'b0;
      else if (push && fifo_full) ovf <= 1'b1;
   end

   tdu_alu #(.CNT_W(CNT_W), .RES_W(RES_W)) u_alu (
      .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width),
      .head_valid(!fifo_empty),
      .head_sync(rd_ent[EW-1]),
      .head_event(rd_ent[EW-2]),
      .head_ts(rd_ent[CNT_W-1:0]),
      .pop(pop),
      .res_ready(res_ready), .res_valid(res_valid), .res_data(res_data),
      .have_sync(have_sync)
   );
endmodule

// File: rtl/tdu_checker.sv
module tdu_checker #(
   parameter int RES_W   = 40,
   parameter int HOLDOFF = 6,
   parameter int DEPTH   = 4,
   parameter int LW      = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             acc_sync,
   input logic             acc_event,
   input logic             push,
   input logic             fifo_full,
   input logic [LW-1:0]    fifo_level,
   input logic             res_valid,
   input logic             res_ready,
   input logic [RES_W-1:0] res_data,
   input logic             ovf
);
   localparam int GW = $clog2(HOLDOFF + 2) + 1;

   logic [GW-1:0] gap_s, gap_e;
   logic          seen_s, seen_e, sync_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_s <= '0; gap_e <= '0;
         seen_s <= 1'b0; seen_e <= 1'b0; sync_seen <= 1'b0;
      end else begin
         if (acc_sync) begin gap_s <= GW'(1); seen_s <= 1'b1; sync_seen <= 1'b1; end
         else if (gap_s < GW'(HOLDOFF)) gap_s <= gap_s + 1'b1;
         if (acc_event) begin gap_e <= GW'(1); seen_e <= 1'b1; end
         else if (gap_e < GW'(HOLDOFF)) gap_e <= gap_e + 1'b1;
      end
   end

   AST_SYNC_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      acc_sync && seen_s |-> gap_s >= GW'(HOLDOFF)); // R5
   AST_EVENT_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      acc_event && seen_e |-> gap_e >= GW'(HOLDOFF)); // R5
   AST_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> sync_seen); // R7
   AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_level <= LW'(DEPTH)); // R8
   AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      push && fifo_full |=> ovf); // R8
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf); // R8
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && !res_ready |=> res_valid && $stable(res_data)); // R9
endmodule

bind tdiff_unit tdu_checker #(
   .RES_W(RES_W), .HOLDOFF(HOLDOFF), .DEPTH(DEPTH), .LW(LW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_sync(acc_sync), .acc_event(acc_event),
   .push(push), .fifo_full(fifo_full), .fifo_level(fifo_level),
   .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data), .ovf(ovf)
);

// File: tb/tdiff_unit_test.sv
`timescale 1ns/1ps
module tdiff_unit_test;
   localparam int RES_W = 40;
   localparam int HOLD  = 6;
   localparam int DEPTH = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] cfg_width = 2'b10;
   logic sync_pol = 1'b0, event_pol = 1'b0;
   logic sync_in = 1'b0, event_in = 1'b0;
   logic res_ready = 1'b1;
   logic res_valid, ovf;
   logic [RES_W-1:0] res_data;

   int total = 0, bad = 0;
   bit finished = 1'b0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   tdiff_unit #(.CNT_W(34), .RES_W(RES_W), .HOLDOFF(HOLD), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width),
      .sync_pol(sync_pol), .event_pol(event_pol),
      .sync_in(sync_in), .event_in(event_in),
      .res_ready(res_ready), .res_valid(res_valid), .res_data(res_data), .ovf(ovf)
   );

   // reference model
   typedef struct { bit s; bit e; longint ts; } ent_t;
   ent_t   q[$];
   longint tick = 0;
   longint last_s = -1, last_e = -1;
   bit     prev_s = 0, prev_e = 0;
   longint ref_ts = 0;
   bit     have = 0;
   bit     m_v = 0, m_ovf = 0;
   logic signed [RES_W-1:0] m_out = '0;

   function automatic int mwidth(input logic [1:0] s);
      if (s == 2'b00) return 18;
      if (s == 2'b01) return 27;
      return 34;
   endfunction

   always @(posedge clk) begin
      if (rst_n) begin
         bit full, free, es, ee, as, ae;
         full = (q.size() >= DEPTH);
         free = !m_v || res_ready;
         if (m_v && res_ready) m_v = 0;
         if (q.size() > 0 && free) begin
            ent_t h;
            h = q.pop_front();
            if (h.s) begin ref_ts = h.ts; have = 1; end
            if (h.e && have) begin
               longint span, d;
               span = longint'(1) << mwidth(cfg_width);
               d = (h.ts - ref_ts) & (span - 1);
               if (d >= span / 2) d = d - span;
               m_out = RES_W'(d);
               m_v = 1;
            end
         end
         es = sync_pol ? (prev_s && !sync_in) : (!prev_s && sync_in);
         ee = event_pol ? (prev_e && !event_in) : (!prev_e && event_in);
         prev_s = sync_in; prev_e = event_in;
         as = es && (last_s < 0 || tick - last_s >= HOLD);
         ae = ee && (last_e < 0 || tick - last_e >= HOLD);
         if (as) last_s = tick;
         if (ae) last_e = tick;
         if (as || ae) begin
            if (!full) q.push_back('{as, ae, tick});
            else m_ovf = 1;
         end
         tick++;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         total++;
         if (res_valid !== m_v || (m_v && res_data !== m_out) || ovf !== m_ovf) begin
            bad++;
            $display("FAIL %s: valid=%0b data=%0d ovf=%0b expected valid=%0b data=%0d ovf=%0b",
                     cur_req, res_valid, $signed(res_data), ovf, m_v, m_out, m_ovf);
         end
      end
   end

   task automatic drive(input logic s, input logic e);
      @(negedge clk);
      sync_in = s; event_in = e;
   endtask

   task automatic idle(input int n);
      repeat (n) drive(1'b0, 1'b0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=expired expected=done");
      finish_run();
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      total++;
      if (res_valid !== 1'b0 || ovf !== 1'b0) begin
         bad++;
         $display("FAIL R1: valid=%0b ovf=%0b expected 0 0", res_valid, ovf);
      end
      rst_n = 1'b1;

      // R7 event before any sync
      cur_req = "R7";
      drive(0, 1); idle(10);

      // R2 basic difference, shared sync, same-cycle pair
      cur_req = "R2";
      drive(1, 0); idle(12); drive(0, 1); idle(9); drive(0, 1); idle(10);
      drive(1, 1); idle(10);

      // R4 single-cycle pulses and a long level
      cur_req = "R4";
      drive(1, 0); repeat (20) drive(1, 0); idle(3); drive(0, 1); idle(10);

      // R3 polarity combinations
      cur_req = "R3";
      for (int k = 1; k < 4; k++) begin
         sync_pol = k[1]; event_pol = k[0];
         idle(8);
         drive(1, 0); idle(7); drive(0, 1); drive(0, 1); drive(0, 1); idle(10);
      end
      sync_pol = 0; event_pol = 0; idle(8);

      // R5 holdoff: too-early edges ignored, exact interval accepted
      cur_req = "R5";
      drive(1, 0); idle(2); drive(0, 1); idle(2); drive(0, 1); idle(HOLD - 2);
      drive(0, 1); idle(HOLD - 1); drive(0, 1); idle(10);
      drive(1, 0); idle(HOLD - 1); drive(1, 0); idle(3); drive(0, 1); idle(10);

      // R9 stalled output and irregular ready
      cur_req = "R9";
      res_ready = 0;
      drive(1, 0); idle(7); drive(0, 1); idle(7); drive(0, 1); idle(7);
      @(negedge clk) res_ready = 1;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         res_ready = (k % 3) != 0;
         sync_in = (k % 17) == 2;
         event_in = (k % 7) == 5;
      end
      res_ready = 1; idle(15);

      // R6 width modes: mid width small gap, short width wrap to negative
      cur_req = "R6";
      cfg_width = 2'b01; idle(2);
      drive(1, 0); idle(40); drive(0, 1); idle(10);
      cfg_width = 2'b11; idle(2);
      drive(1, 0); idle(30); drive(0, 1); idle(10);
      cfg_width = 2'b00; idle(2);
      drive(1, 0); idle(131080); drive(0, 1); idle(10);
      cfg_width = 2'b10; idle(2);

      // R8 overflow with stalled consumer
      cur_req = "R8";
      res_ready = 0;
      drive(1, 0); idle(7);
      for (int k = 0; k < 9; k++) begin drive(0, 1); idle(7); end
      res_ready = 1; idle(20);
      drive(1, 0); idle(8); drive(0, 1); idle(10);

      finish_run();
   end
endmodule